// File: doc/BRIEF.md
# Per-Core Linked-Load Reservation Tracker

This block sits between one processor core and the memory-side port of that core's cache controller. It handles the two halves of a linked-load / store-conditional pair. A linked load (LL) is forwarded to memory. When the memory answers, the block returns the loaded word to the core and keeps the address together with the reservation key that came back. A store-conditional (SC) whose address matches a live reservation is forwarded with that key attached. Memory then decides the outcome and reports 0 for success and any other value for failure. An SC with no live reservation, or with a different address, is failed inside the block and never reaches memory.

The memory status uses one polarity, and cores do not all agree on it. A static parameter picks what the core receives. With `SUCCESS_NONZERO = 1` the core gets 1 for success and 0 for failure. With `SUCCESS_NONZERO = 0` the core gets 0 for success and 1 for failure. The block holds one reservation and serves one transaction at a time.

All four ports are valid/ready streams. A transfer happens on a clock edge where both valid and ready are high. Once the block raises a valid, it holds that valid and all payload fields unchanged until the transfer happens. The block raises `core_req_ready` only when it is idle: no command pending, no memory response awaited, and no core response waiting. Back-pressure from memory or from the core stalls the block without losing anything.

Top module: `resv_tracker`

## Requirements
- R1: After reset, `core_req_ready` is 1, and `mem_cmd_valid`, `mem_rsp_ready` and `core_rsp_valid` are 0. No reservation is live, so an SC issued first after reset fails locally.
- R2: An LL request (`core_req_op` = 0) produces one memory command with op 0 and the same address. The `mem_rsp_data` word of its response is returned unchanged on `core_rsp_data`.
- R3: The response to an LL records the command address and `mem_rsp_key` as the live reservation. A later SC (`core_req_op` = 1) to that address produces one memory command with op 1, the same address, the SC data, and the recorded key on `mem_cmd_key`.
- R4: An SC with no live reservation, or whose address differs from the recorded one, produces no memory command. The core receives the failure code one cycle after the request is accepted.
- R5: Every accepted SC ends the reservation, whether it is forwarded or failed locally and whatever memory answers. A second SC to the same address then fails locally.
- R6: For a forwarded SC, `mem_rsp_data` equal to 0 means success and any nonzero value means failure. The core receives 1 for success and 0 for failure when `SUCCESS_NONZERO` = 1, or 0 for success and 1 for failure when it is 0. A local failure uses the same failure code.
- R7: Each raised valid, with its payload, stays stable until accepted. Only one transaction is in flight. `core_req_ready` is high only when no command, memory response or core response is pending.
- R8: A new LL replaces the recorded address and key. After that, an SC to the old address fails locally, and an SC to the new address carries the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | 1 | Core request valid |
| core_req_ready | output | 1 | Block can accept a core request |
| core_req_op | input | 1 | 0 = LL, 1 = SC |
| core_req_addr | input | ADDR_W (40) | Physical address |
| core_req_wdata | input | DATA_W (32) | SC store data |
| core_rsp_valid | output | 1 | Response to the core valid |
| core_rsp_ready | input | 1 | Core accepts the response |
| core_rsp_data | output | DATA_W (32) | LL data or SC status code |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_op | output | 1 | 0 = LL, 1 = SC |
| mem_cmd_addr | output | ADDR_W (40) | Command address |
| mem_cmd_wdata | output | DATA_W (32) | SC data |
| mem_cmd_key | output | KEY_W (32) | Reservation key for SC |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Block accepts a memory response |
| mem_rsp_data | input | DATA_W (32) | LL data, or SC status (0 = success) |
| mem_rsp_key | input | KEY_W (32) | Key returned for an LL |

## Verification
A wrong recorded key or address shows up at the next SC. Either the SC appears on the memory port carrying a stale key, or it is answered one cycle after acceptance without any command. The bench catches this the first time an SC follows an LL. A reservation that survives an SC is exposed by the second SC to the same address, which must not reach memory. A polarity error flips `core_rsp_data` on the very first SC response. Back-pressure faults show as a valid or payload changing while ready is held low. These are checked on every stalled cycle.

// File: rtl/rsvt_pkg.sv
package rsvt_pkg;
  typedef enum logic {
    OP_LL = 1'b0,
    OP_SC = 1'b1
  } rsvt_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RSP  = 2'd3
  } rsvt_state_e;
endpackage

// File: rtl/rsvt_store.sv
module rsvt_store #(
  parameter int ADDR_W = 40,
  parameter int KEY_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [KEY_W-1:0]  load_key,
  input  logic              clear,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              hit,
  output logic [KEY_W-1:0]  key
);
  logic              live_q;
  logic [ADDR_W-1:0] addr_q;
  logic [KEY_W-1:0]  key_q;

  // Load and clear are never raised together by the sequencer; load wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      addr_q <= '0;
      key_q  <= '0;
    end else if (load) begin
      live_q <= 1'b1;
      addr_q <= load_addr;
      key_q  <= load_key;
    end else if (clear) begin
      live_q <= 1'b0;
    end
  end

  assign hit = live_q && (addr_q == probe_addr);
  assign key = key_q;
endmodule

// File: rtl/rsvt_xlate.sv
module rsvt_xlate #(
  parameter int DATA_W          = 32,
  parameter bit SUCCESS_NONZERO = 1'b1
) (
  input  logic              ok,
  output logic [DATA_W-1:0] status
);
  logic code;

  generate
    if (SUCCESS_NONZERO) begin : g_nonzero_ok
      assign code = ok;
    end else begin : g_zero_ok
      assign code = ~ok;
    end
  endgenerate

  assign status = {{(DATA_W-1){1'b0}}, code};
endmodule

// File: rtl/rsvt_seq.sv
module rsvt_seq
  import rsvt_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 32,
  parameter int KEY_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req_valid,
  output logic              core_req_ready,
  input  logic              core_req_op,
  input  logic [ADDR_W-1:0] core_req_addr,
  input  logic [DATA_W-1:0] core_req_wdata,
  output logic              core_rsp_valid,
  input  logic              core_rsp_ready,
  output logic [DATA_W-1:0] core_rsp_data,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_op,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic [DATA_W-1:0] mem_cmd_wdata,
  output logic [KEY_W-1:0]  mem_cmd_key,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic [KEY_W-1:0]  mem_rsp_key,
  input  logic              store_hit,
  input  logic [KEY_W-1:0]  store_key,
  output logic              store_load,
  output logic [ADDR_W-1:0] store_load_addr,
  output logic [KEY_W-1:0]  store_load_key,
  output logic              store_clear,
  output logic              xl_ok,
  input  logic [DATA_W-1:0] xl_status
);
  rsvt_state_e       state_q;
  logic              op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [KEY_W-1:0]  key_q;
  logic [DATA_W-1:0] rsp_q;

  logic req_fire, cmd_fire, mrsp_fire, crsp_fire, is_sc, fwd;

  assign core_req_ready = (state_q == ST_IDLE);
  assign mem_cmd_valid  = (state_q == ST_CMD);
  assign mem_rsp_ready  = (state_q == ST_WAIT);
  assign core_rsp_valid = (state_q == ST_RSP);

  assign req_fire  = core_req_valid && core_req_ready;
  assign cmd_fire  = mem_cmd_valid && mem_cmd_ready;
  assign mrsp_fire = mem_rsp_valid && mem_rsp_ready;
  assign crsp_fire = core_rsp_valid && core_rsp_ready;

  assign is_sc = (core_req_op == OP_SC);
  // An LL always goes out; an SC only with a matching live reservation.
  assign fwd   = !is_sc || store_hit;

  // Status mapping: memory 0 = success; local rejection always fails.
  assign xl_ok = (state_q == ST_WAIT) && (mem_rsp_data == '0);

  assign store_clear     = req_fire && is_sc;
  assign store_load      = mrsp_fire && (op_q == OP_LL);
  assign store_load_addr = addr_q;
  assign store_load_key  = mem_rsp_key;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_LL;
      addr_q  <= '0;
      wdata_q <= '0;
      key_q   <= '0;
      rsp_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_fire) begin
            op_q    <= core_req_op;
            addr_q  <= core_req_addr;
            wdata_q <= core_req_wdata;
            key_q   <= store_key;
            if (fwd) begin
              state_q <= ST_CMD;
            end else begin
              rsp_q   <= xl_status;
              state_q <= ST_RSP;
            end
          end
        end
        ST_CMD: begin
          if (cmd_fire) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mrsp_fire) begin
            rsp_q   <= (op_q == OP_LL) ? mem_rsp_data : xl_status;
            state_q <= ST_RSP;
          end
        end
        ST_RSP: begin
          if (crsp_fire) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_cmd_op    = op_q;
  assign mem_cmd_addr  = addr_q;
  assign mem_cmd_wdata = wdata_q;
  assign mem_cmd_key   = key_q;
  assign core_rsp_data = rsp_q;
endmodule

// File: rtl/resv_tracker.sv
module resv_tracker #(
  parameter int ADDR_W          = 40,
  parameter int DATA_W          = 32,
  parameter int KEY_W           = 32,
  parameter bit SUCCESS_NONZERO = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req_valid,
  output logic              core_req_ready,
  input  logic              core_req_op,
  input  logic [ADDR_W-1:0] core_req_addr,
  input  logic [DATA_W-1:0] core_req_wdata,
  output logic              core_rsp_valid,
  input  logic              core_rsp_ready,
  output logic [DATA_W-1:0] core_rsp_data,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_op,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic [DATA_W-1:0] mem_cmd_wdata,
  output logic [KEY_W-1:0]  mem_cmd_key,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic [KEY_W-1:0]  mem_rsp_key
);
  logic              store_hit, store_load, store_clear, xl_ok;
  logic [KEY_W-1:0]  store_key, store_load_key;
  logic [ADDR_W-1:0] store_load_addr;
  logic [DATA_W-1:0] xl_status;

  rsvt_store #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (store_load),
    .load_addr  (store_load_addr),
    .load_key   (store_load_key),
    .clear      (store_clear),
    .probe_addr (core_req_addr),
    .hit        (store_hit),
    .key        (store_key)
  );

  rsvt_xlate #(.DATA_W(DATA_W), .SUCCESS_NONZERO(SUCCESS_NONZERO)) u_xlate (
    .ok     (xl_ok),
    .status (xl_status)
  );

  rsvt_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W)) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .core_req_valid  (core_req_valid),
    .core_req_ready  (core_req_ready),
    .core_req_op     (core_req_op),
    .core_req_addr   (core_req_addr),
    .core_req_wdata  (core_req_wdata),
    .core_rsp_valid  (core_rsp_valid),
    .core_rsp_ready  (core_rsp_ready),
    .core_rsp_data   (core_rsp_data),
    .mem_cmd_valid   (mem_cmd_valid),
    .mem_cmd_ready   (mem_cmd_ready),
    .mem_cmd_op      (mem_cmd_op),
    .mem_cmd_addr    (mem_cmd_addr),
    .mem_cmd_wdata   (mem_cmd_wdata),
    .mem_cmd_key     (mem_cmd_key),
    .mem_rsp_valid   (mem_rsp_valid),
    .mem_rsp_ready   (mem_rsp_ready),
    .mem_rsp_data    (mem_rsp_data),
    .mem_rsp_key     (mem_rsp_key),
    .store_hit       (store_hit),
    .store_key       (store_key),
    .store_load      (store_load),
    .store_load_addr (store_load_addr),
    .store_load_key  (store_load_key),
    .store_clear     (store_clear),
    .xl_ok           (xl_ok),
    .xl_status       (xl_status)
  );
endmodule

// File: rtl/resv_tracker_chk.sv
module resv_tracker_chk #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 32,
  parameter int KEY_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_req_valid,
  input logic              core_req_ready,
  input logic              core_req_op,
  input logic              core_rsp_valid,
  input logic              core_rsp_ready,
  input logic [DATA_W-1:0] core_rsp_data,
  input logic              mem_cmd_valid,
  input logic              mem_cmd_ready,
  input logic              mem_cmd_op,
  input logic [ADDR_W-1:0] mem_cmd_addr,
  input logic [DATA_W-1:0] mem_cmd_wdata,
  input logic [KEY_W-1:0]  mem_cmd_key,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready,
  input logic [KEY_W-1:0]  mem_rsp_key
);
  // Port-level shadow of the reservation, built only from handshakes.
  logic              last_ll_q;
  logic [ADDR_W-1:0] ll_addr_q, cmd_addr_q;
  logic [KEY_W-1:0]  ll_key_q;
  logic              armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_ll_q  <= 1'b0;
      cmd_addr_q <= '0;
      ll_addr_q  <= '0;
      ll_key_q   <= '0;
      armed_q    <= 1'b0;
    end else begin
      if (mem_cmd_valid && mem_cmd_ready) begin
        last_ll_q  <= (mem_cmd_op == 1'b0);
        cmd_addr_q <= mem_cmd_addr;
      end
      if (mem_rsp_valid && mem_rsp_ready && last_ll_q) begin
        ll_key_q  <= mem_rsp_key;
        ll_addr_q <= cmd_addr_q;
        armed_q   <= 1'b1;
      end else if (core_req_valid && core_req_ready && core_req_op) begin
        armed_q <= 1'b0;
      end
    end
  end

  a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid && $stable(mem_cmd_op)
      && $stable(mem_cmd_addr) && $stable(mem_cmd_wdata) && $stable(mem_cmd_key));

  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsp_valid && !core_rsp_ready |=> core_rsp_valid && $stable(core_rsp_data));

  a_r7_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    core_req_ready |-> !mem_cmd_valid && !mem_rsp_ready && !core_rsp_valid);

  a_r7_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_cmd_valid, mem_rsp_ready, core_rsp_valid}) <= 1);

  a_r3_sc_key: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && mem_cmd_op |-> mem_cmd_key == ll_key_q && mem_cmd_addr == ll_addr_q);

  a_r5_sc_needs_ll: assert property (@(posedge clk) disable iff (!rst_n)
    core_req_valid && core_req_ready && core_req_op && !armed_q
      |=> !mem_cmd_valid && core_rsp_valid);
endmodule

bind resv_tracker resv_tracker_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .core_req_valid (core_req_valid),
  .core_req_ready (core_req_ready),
  .core_req_op    (core_req_op),
  .core_rsp_valid (core_rsp_valid),
  .core_rsp_ready (core_rsp_ready),
  .core_rsp_data  (core_rsp_data),
  .mem_cmd_valid  (mem_cmd_valid),
  .mem_cmd_ready  (mem_cmd_ready),
  .mem_cmd_op     (mem_cmd_op),
  .mem_cmd_addr   (mem_cmd_addr),
  .mem_cmd_wdata  (mem_cmd_wdata),
  .mem_cmd_key    (mem_cmd_key),
  .mem_rsp_valid  (mem_rsp_valid),
  .mem_rsp_ready  (mem_rsp_ready),
  .mem_rsp_key    (mem_rsp_key)
);

// File: tb/test_resv_tracker.sv
module test_resv_tracker;
  localparam int AW = 40;
  localparam int DW = 32;
  localparam int KW = 32;
  localparam bit SNZ = 1'b1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          core_req_valid, core_req_ready, core_req_op;
  logic [AW-1:0] core_req_addr;
  logic [DW-1:0] core_req_wdata;
  logic          core_rsp_valid, core_rsp_ready;
  logic [DW-1:0] core_rsp_data;
  logic          mem_cmd_valid, mem_cmd_ready, mem_cmd_op;
  logic [AW-1:0] mem_cmd_addr;
  logic [DW-1:0] mem_cmd_wdata;
  logic [KW-1:0] mem_cmd_key;
  logic          mem_rsp_valid, mem_rsp_ready;
  logic [DW-1:0] mem_rsp_data;
  logic [KW-1:0] mem_rsp_key;

  resv_tracker #(.ADDR_W(AW), .DATA_W(DW), .KEY_W(KW), .SUCCESS_NONZERO(SNZ)) i_resv_tracker (
    .clk(clk), .rst_n(rst_n),
    .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
    .core_req_op(core_req_op), .core_req_addr(core_req_addr), .core_req_wdata(core_req_wdata),
    .core_rsp_valid(core_rsp_valid), .core_rsp_ready(core_rsp_ready), .core_rsp_data(core_rsp_data),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready), .mem_cmd_op(mem_cmd_op),
    .mem_cmd_addr(mem_cmd_addr), .mem_cmd_wdata(mem_cmd_wdata), .mem_cmd_key(mem_cmd_key),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_key(mem_rsp_key)
  );

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  // Bench model of the reservation.
  bit            m_live = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [KW-1:0] m_key  = '0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] core_code(bit ok);
    bit c = SNZ ? ok : !ok;
    return {{(DW-1){1'b0}}, c};
  endfunction

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_op(bit op, logic [AW-1:0] a, logic [DW-1:0] d,
                       logic [DW-1:0] mdata, logic [KW-1:0] mkey, int stall, string tag);
    bit            lfail = op && !(m_live && m_addr == a);
    logic [KW-1:0] exp_key = m_key;
    logic [DW-1:0] exp_rsp;
    string t_lf  = (tag == "") ? "R4" : tag;
    string t_key = (tag == "") ? "R3" : tag;
    @(negedge clk);
    core_req_valid = 1'b1; core_req_op = op; core_req_addr = a; core_req_wdata = d;
    while (!core_req_ready) @(negedge clk);
    @(negedge clk);
    core_req_valid = 1'b0;
    if (lfail) begin
      chk({t_lf, " no command"}, 64'(mem_cmd_valid), 64'd0);
      chk({t_lf, " quick response"}, 64'(core_rsp_valid), 64'd1);
      exp_rsp = core_code(1'b0);
    end else begin
      for (int i = 0; i <= stall; i++) begin
        chk("R7 cmd held", 64'(mem_cmd_valid), 64'd1);
        chk(op ? t_key : "R2", 64'(mem_cmd_op), 64'(op));
        chk(op ? t_key : "R2", 64'(mem_cmd_addr), 64'(a));
        if (op) begin
          chk(t_key, 64'(mem_cmd_wdata), 64'(d));
          chk({t_key, " key"}, 64'(mem_cmd_key), 64'(exp_key));
        end
        if (i < stall) @(negedge clk);
      end
      mem_cmd_ready = 1'b1;
      @(negedge clk);
      mem_cmd_ready = 1'b0;
      chk("R7 wait phase", 64'({mem_cmd_valid, mem_rsp_ready}), 64'b01);
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        chk("R7 no early rsp", 64'(core_rsp_valid), 64'd0);
      end
      mem_rsp_valid = 1'b1; mem_rsp_data = mdata; mem_rsp_key = mkey;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      exp_rsp = op ? core_code(mdata == '0) : mdata;
    end
    if (op) m_live = 1'b0;
    else begin m_live = 1'b1; m_addr = a; m_key = mkey; end
    for (int i = 0; i <= stall; i++) begin
      chk("R7 rsp held", 64'(core_rsp_valid), 64'd1);
      chk(op ? (lfail ? t_lf : "R6") : "R2", 64'(core_rsp_data), 64'(exp_rsp));
      if (i < stall) @(negedge clk);
    end
    core_rsp_ready = 1'b1;
    @(negedge clk);
    core_rsp_ready = 1'b0;
    chk("R7 back to idle", 64'({core_rsp_valid, core_req_ready}), 64'b01);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_sim();
  end

  initial begin
    logic [AW-1:0] pool [4];
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; core_req_valid = 1'b0; core_req_op = 1'b0; core_req_addr = '0;
    core_req_wdata = '0; core_rsp_ready = 1'b0; mem_cmd_ready = 1'b0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_key = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", 64'({core_req_ready, mem_cmd_valid, mem_rsp_ready, core_rsp_valid}), 64'b1000);
    pool[0] = 40'hA5_0000_1000; pool[1] = 40'hA5_0000_1004;
    pool[2] = 40'hFF_8000_0040; pool[3] = 40'h00_0000_0000;
    // R1: first SC after reset fails locally
    do_op(1'b1, pool[0], 32'h1111, 32'd0, 32'd0, 0, "R1");
    // R2/R3/R6 success, then R5 second SC fails locally
    do_op(1'b0, pool[0], 32'd0, 32'hDEAD_BEEF, 32'hCAFE_0001, 1, "");
    do_op(1'b1, pool[0], 32'h2222, 32'd0, 32'd0, 2, "");
    do_op(1'b1, pool[0], 32'h3333, 32'd0, 32'd0, 0, "R5");
    // R5: memory failure also ends the reservation
    do_op(1'b0, pool[1], 32'd0, 32'h0000_0042, 32'hCAFE_0002, 0, "");
    do_op(1'b1, pool[1], 32'h4444, 32'd1, 32'd0, 0, "");
    do_op(1'b1, pool[1], 32'h5555, 32'd0, 32'd0, 0, "R5");
    // R8: newer LL replaces reservation
    do_op(1'b0, pool[2], 32'd0, 32'h0BAD_F00D, 32'h1234_5678, 0, "");
    do_op(1'b0, pool[3], 32'd0, 32'h7777_7777, 32'h8765_4321, 0, "");
    do_op(1'b1, pool[2], 32'h6666, 32'd0, 32'd0, 0, "R8");
    do_op(1'b0, pool[2], 32'd0, 32'h1, 32'h1357_9BDF, 0, "");
    do_op(1'b0, pool[3], 32'd0, 32'h2, 32'h2468_ACE0, 0, "");
    do_op(1'b1, pool[3], 32'h9999, 32'hFFFF_FFFF, 32'd0, 3, "R8");
    // Constrained random mix
    for (int n = 0; n < 500; n++) begin
      bit            op   = ($urandom % 3) != 0;
      logic [AW-1:0] a    = pool[$urandom % 4];
      logic [DW-1:0] md;
      if (($urandom % 8) == 0) a = a ^ 40'h10;
      if (op) md = ($urandom % 2) ? 32'd0 : (($urandom % 2) ? 32'd1 : ($urandom | 32'd1));
      else    md = $urandom;
      do_op(op, a, $urandom, md, $urandom, int'($urandom % 4), "");
    end
    finish_sim();
  end
endmodule